// File: doc/BRIEF.md
# Audio bit clock and frame sync generator

This block sits on the master side of a serial audio port. It divides a fast reference clock by a programmable integer to make the bit clock. It then counts bit clocks to make a periodic frame sync. The frame period and the sync width are each held in their own field, and both fields store their value minus one. Two independent inversion bits select the active edge of the bit clock and the active level of the frame sync. A one-reference-cycle strobe marks the first reference cycle of every frame.

Software picks the field values to suit the serial format. For left-justified or I2S-style framing, the width is set to half the frame length minus one, which gives a frame clock near 50% duty. For DSP-style framing, the width field is zero, which gives a sync pulse one bit clock long. The block also flags any setting whose frame has fewer bit clocks than the word length times the channel count.

All timing settings are captured at a frame boundary. A running frame therefore never changes shape partway through. When the enable is dropped, both clocks go to their resting levels and the counters return to zero.

Top module: `aud_clk_fs_gen`

## Requirements
- R1: The bit period lasts max(cfg_div,1)+1 reference cycles. A divider field of 0 is treated as 1.
- R2: Each bit period holds the un-inverted bit clock low for its first floor(ratio/2) reference cycles and high for the remaining cycles. With cfg_bclk_inv=0 the frame therefore opens on a falling edge, where transmit data changes, and the rising edge falls mid-bit, where receive data is sampled. With cfg_bclk_inv=1 the output is inverted.
- R3: A frame lasts cfg_period+1 bit periods. frame_start pulses once per frame, so successive pulses are (cfg_period+1)*(max(cfg_div,1)+1) reference cycles apart.
- R4: The frame sync is active for the first cfg_width+1 bit periods of a frame, or for the whole frame when cfg_width >= cfg_period. Its active level is low when cfg_fs_inv=0 and high when cfg_fs_inv=1.
- R5: frame_start is high for exactly one reference cycle, the first cycle of each frame. The first frame begins in the cycle after enable is first sampled high.
- R6: One cycle after enable is sampled low, the outputs rest as follows: bclk equals cfg_bclk_inv, fsync equals the inverse of cfg_fs_inv, and frame_start is 0. While at rest these levels follow the live polarity inputs, and the counters restart from zero on the next enable.
- R7: cfg_div, cfg_period, cfg_width and both polarity bits are captured only when a frame starts, either at enable or at the last bit of the previous frame. A change made mid-frame does not alter the frame in progress.
- R8: cfg_err is registered. One cycle after a setting in which cfg_period+1 is less than cfg_wlen*cfg_nch it reads 1, and otherwise it reads 0.
- R9: During reset, bclk, fsync and frame_start take the resting levels of R6, and cfg_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator |
| cfg_div | input | 8 | Bit clock ratio minus one |
| cfg_period | input | 12 | Frame length in bit clocks minus one |
| cfg_width | input | 8 | Sync active length in bit clocks minus one |
| cfg_bclk_inv | input | 1 | Invert the bit clock |
| cfg_fs_inv | input | 1 | Invert the frame sync (active high) |
| cfg_wlen | input | 6 | Word length in bits, used for the bandwidth check |
| cfg_nch | input | 4 | Channels per frame, used for the bandwidth check |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| frame_start | output | 1 | One-cycle strobe on the first cycle of each frame |
| cfg_err | output | 1 | Frame too short for words times channels |

## Verification
The assertions run on every cycle. They check the resting levels after enable falls, and that the frame opens one cycle after enable rises. They also check that frame_start is a single-cycle pulse, that the bit clock and sync sit at their captured active phase when a frame opens, and that the error flag has its one-cycle latency.

Other behaviours need a full run before they can be judged. These are the divider ratio and duty split, the frame spacing, the sync width (including a width wider than the frame), and odd ratios with the zero-divider floor. The same holds for mid-frame setting changes that must wait for the boundary. The bench's scenarios show these by comparing against a behavioural model on every clock and by measuring the spacing between frame strobes.

// File: rtl/afg_pkg.sv
package afg_pkg;
  localparam int DIV_W = 8;
  localparam int PER_W = 12;
  localparam int WID_W = 8;

  typedef struct packed {
    logic [DIV_W-1:0] div_eff;  // ratio minus one, floored at 1
    logic [PER_W-1:0] per;
    logic [WID_W-1:0] wid;
    logic             fs_inv;
    logic             bk_inv;
  } afg_cfg_t;
endpackage

// File: rtl/afg_cfg_hold.sv
module afg_cfg_hold
  import afg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic [PER_W-1:0] per_in,
  input  logic [WID_W-1:0] wid_in,
  input  logic             fs_inv_in,
  input  logic             bk_inv_in,
  output afg_cfg_t         cfg_q
);
  afg_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load) begin
      cfg_d.div_eff = (div_in == '0) ? DIV_W'(1) : div_in;
      cfg_d.per     = per_in;
      cfg_d.wid     = wid_in;
      cfg_d.fs_inv  = fs_inv_in;
      cfg_d.bk_inv  = bk_inv_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/afg_bit_timer.sv
module afg_bit_timer
  import afg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [DIV_W-1:0] div_eff,
  output logic             bit_end,
  output logic             bit_begin,
  output logic             phase_hi
);
  localparam int HW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [HW-1:0]    half;

  assign half      = ({1'b0, div_eff} + HW'(1)) >> 1;
  assign bit_end   = (cnt_q == div_eff);
  assign bit_begin = (cnt_q == '0);
  assign phase_hi  = ({1'b0, cnt_q} >= half);

  always_comb begin
    cnt_d = '0;
    if (adv && !bit_end) cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/afg_frame_ctr.sv
module afg_frame_ctr
  import afg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             bit_end,
  input  logic [PER_W-1:0] per,
  input  logic [WID_W-1:0] wid,
  output logic             last_bit,
  output logic             first_bit,
  output logic             sync_act
);
  localparam int CW = (PER_W > WID_W) ? PER_W : WID_W;

  logic [PER_W-1:0] idx_q, idx_d;

  assign last_bit  = (idx_q == per);
  assign first_bit = (idx_q == '0);
  assign sync_act  = (CW'(idx_q) <= CW'(wid));

  always_comb begin
    idx_d = idx_q;
    if (!adv)          idx_d = '0;
    else if (bit_end)  idx_d = last_bit ? '0 : idx_q + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/aud_clk_fs_gen.sv
module aud_clk_fs_gen
  import afg_pkg::*;
#(
  parameter int WLEN_W = 6,
  parameter int NCH_W  = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic              cfg_bclk_inv,
  input  logic              cfg_fs_inv,
  input  logic [WLEN_W-1:0] cfg_wlen,
  input  logic [NCH_W-1:0]  cfg_nch,
  output logic              bclk,
  output logic              fsync,
  output logic              frame_start,
  output logic              cfg_err
);
  localparam int CMP_W = PER_W + WLEN_W + NCH_W;

  afg_cfg_t   cur;
  logic       run_q, run_d;
  logic       err_q, err_d;
  logic       adv, load;
  logic       bit_end, bit_begin, phase_hi;
  logic       last_bit, first_bit, sync_act;
  logic [CMP_W-1:0] frame_len, need_len;
  logic       lat_fs_inv, lat_bk_inv;

  assign adv  = run_q & enable;
  assign load = enable & (~run_q | (bit_end & last_bit));

  afg_cfg_hold u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .div_in(cfg_div), .per_in(cfg_period), .wid_in(cfg_width),
    .fs_inv_in(cfg_fs_inv), .bk_inv_in(cfg_bclk_inv), .cfg_q(cur)
  );

  afg_bit_timer u_bit (
    .clk(clk), .rst_n(rst_n), .adv(adv), .div_eff(cur.div_eff),
    .bit_end(bit_end), .bit_begin(bit_begin), .phase_hi(phase_hi)
  );

  afg_frame_ctr u_frm (
    .clk(clk), .rst_n(rst_n), .adv(adv), .bit_end(bit_end),
    .per(cur.per), .wid(cur.wid),
    .last_bit(last_bit), .first_bit(first_bit), .sync_act(sync_act)
  );

  assign frame_len = CMP_W'(cfg_period) + CMP_W'(1);
  assign need_len  = CMP_W'(cfg_wlen) * CMP_W'(cfg_nch);

  always_comb begin
    run_d = enable;
    err_d = (frame_len < need_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      run_q <= run_d;
      err_q <= err_d;
    end
  end

  assign lat_fs_inv  = cur.fs_inv;
  assign lat_bk_inv  = cur.bk_inv;
  assign bclk        = run_q ? (phase_hi ^ cur.bk_inv) : cfg_bclk_inv;
  assign fsync       = run_q ? (sync_act ? cur.fs_inv : ~cur.fs_inv) : ~cfg_fs_inv;
  assign frame_start = run_q & first_bit & bit_begin;
  assign cfg_err     = err_q;
endmodule

// File: rtl/aud_clk_fs_gen_chk.sv
module aud_clk_fs_gen_chk
  import afg_pkg::*;
#(
  parameter int WLEN_W = 6,
  parameter int NCH_W  = 4
)(
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [PER_W-1:0]  cfg_period,
  input logic              cfg_bclk_inv,
  input logic              cfg_fs_inv,
  input logic [WLEN_W-1:0] cfg_wlen,
  input logic [NCH_W-1:0]  cfg_nch,
  input logic              bclk,
  input logic              fsync,
  input logic              frame_start,
  input logic              cfg_err,
  input logic              lat_fs_inv,
  input logic              lat_bk_inv
);
  localparam int CMP_W = PER_W + WLEN_W + NCH_W;
  logic armed;
  logic short_frame;

  assign short_frame = (CMP_W'(cfg_period) + CMP_W'(1)) < (CMP_W'(cfg_wlen) * CMP_W'(cfg_nch));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r6_rest_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(!enable)) |-> (bclk == cfg_bclk_inv && fsync == !cfg_fs_inv && !frame_start));

  a_r5_first_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(enable)) |=> frame_start);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  a_r4_sync_active_at_open: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (fsync == lat_fs_inv));

  a_r2_bclk_low_phase_at_open: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (bclk == lat_bk_inv));

  a_r8_err_latency: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cfg_err == $past(short_frame)));
endmodule

bind aud_clk_fs_gen aud_clk_fs_gen_chk #(.WLEN_W(WLEN_W), .NCH_W(NCH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_period(cfg_period),
  .cfg_bclk_inv(cfg_bclk_inv), .cfg_fs_inv(cfg_fs_inv),
  .cfg_wlen(cfg_wlen), .cfg_nch(cfg_nch),
  .bclk(bclk), .fsync(fsync), .frame_start(frame_start), .cfg_err(cfg_err),
  .lat_fs_inv(lat_fs_inv), .lat_bk_inv(lat_bk_inv)
);

// File: tb/aud_clk_fs_gen_tb_top.sv
`timescale 1ns/1ps
module aud_clk_fs_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic [11:0] cfg_period = 12'd31;
  logic [7:0]  cfg_width = 8'd15;
  logic        cfg_bclk_inv = 1'b0;
  logic        cfg_fs_inv = 1'b0;
  logic [5:0]  cfg_wlen = 6'd16;
  logic [3:0]  cfg_nch = 4'd2;
  logic        bclk, fsync, frame_start, cfg_err;

  always #2.5 clk = ~clk;

  aud_clk_fs_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div(cfg_div),
    .cfg_period(cfg_period), .cfg_width(cfg_width), .cfg_bclk_inv(cfg_bclk_inv),
    .cfg_fs_inv(cfg_fs_inv), .cfg_wlen(cfg_wlen), .cfg_nch(cfg_nch),
    .bclk(bclk), .fsync(fsync), .frame_start(frame_start), .cfg_err(cfg_err)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // behavioural reference state
  bit m_run, m_fsi, m_bki, m_err;
  int m_ph, m_bit, m_ratio, m_per, m_wid;

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag, input string what);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void model_edge();
    if (!rst_n) begin
      m_run = 0; m_ph = 0; m_bit = 0; m_err = 0;
      return;
    end
    m_err = (int'(cfg_period) + 1) < (int'(cfg_wlen) * int'(cfg_nch));
    if (!enable) begin
      m_run = 0; m_ph = 0; m_bit = 0;
    end else if (!m_run) begin
      m_run = 1; m_ph = 0; m_bit = 0;
      m_ratio = (cfg_div == 0 ? 1 : int'(cfg_div)) + 1;
      m_per = cfg_period; m_wid = cfg_width; m_fsi = cfg_fs_inv; m_bki = cfg_bclk_inv;
    end else if (m_ph == m_ratio - 1) begin
      m_ph = 0;
      if (m_bit == m_per) begin
        m_bit = 0;
        m_ratio = (cfg_div == 0 ? 1 : int'(cfg_div)) + 1;
        m_per = cfg_period; m_wid = cfg_width; m_fsi = cfg_fs_inv; m_bki = cfg_bclk_inv;
      end else m_bit++;
    end else m_ph++;
  endfunction

  task automatic compare();
    if (!m_run) begin
      chk(bclk, cfg_bclk_inv, "R6", "rest bclk");
      chk(fsync, !cfg_fs_inv, "R6", "rest fsync");
      chk(frame_start, 1'b0, "R6", "rest frame_start");
    end else begin
      chk(bclk, (m_ph >= m_ratio / 2) ^ m_bki, "R2", "bclk");
      chk(fsync, (m_bit <= m_wid) ? m_fsi : !m_fsi, "R4", "fsync");
      chk(frame_start, (m_ph == 0 && m_bit == 0), "R5", "frame_start");
    end
    chk(cfg_err, m_err, "R8", "cfg_err");
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // returns the number of cycles until frame_start is seen
  task automatic to_start(output int n);
    n = 0;
    do begin step(); n++; end while (!frame_start && n < 5000);
  endtask

  task automatic measure(input int exp, input string tag);
    int n;
    to_start(n);
    to_start(n);
    chk_int(n, exp, tag, "frame spacing");
  endtask

  initial begin
    int n;
    run(3);
    // R9: outputs at rest and no error while in reset
    chk(bclk, 1'b0, "R9", "reset bclk");
    chk(fsync, 1'b1, "R9", "reset fsync");
    chk(frame_start, 1'b0, "R9", "reset frame_start");
    chk(cfg_err, 1'b0, "R9", "reset cfg_err");
    @(negedge clk); rst_n = 1'b1;
    run(4);

    // two-phase framing, ratio 2, 32 bits per frame (R1, R3)
    enable = 1'b1;
    step();
    chk(frame_start, 1'b1, "R5", "first frame after enable");
    measure(64, "R3");
    cfg_bclk_inv = 1'b1; cfg_fs_inv = 1'b1;
    run(10);
    measure(64, "R2");
    run(40);

    // rest, live polarity while idle (R6)
    enable = 1'b0;
    run(3);
    cfg_bclk_inv = 1'b0; cfg_fs_inv = 1'b0;
    run(3);

    // one-bit sync pulse, ratio 4, 64 bits (R1, R4)
    cfg_div = 8'd3; cfg_period = 12'd63; cfg_width = 8'd0; cfg_wlen = 6'd32;
    enable = 1'b1;
    measure(256, "R1");
    run(30);

    // odd ratio, sync wider than frame, short frame flagged (R4, R8)
    enable = 1'b0; run(2);
    cfg_div = 8'd2; cfg_period = 12'd9; cfg_width = 8'd20; cfg_wlen = 6'd16; cfg_fs_inv = 1'b1;
    step();
    chk(cfg_err, 1'b1, "R8", "short frame flagged");
    enable = 1'b1;
    measure(30, "R1");
    run(20);

    // zero divider floored to ratio 2 (R1)
    enable = 1'b0; run(2);
    cfg_div = 8'd0; cfg_period = 12'd4; cfg_width = 8'd1; cfg_fs_inv = 1'b0; cfg_nch = 4'd0;
    enable = 1'b1;
    measure(10, "R1");
    run(12);

    // mid-frame change waits for the boundary (R7)
    enable = 1'b0; run(2);
    cfg_div = 8'd2; cfg_period = 12'd9; cfg_width = 8'd4;
    enable = 1'b1;
    to_start(n);
    run(5);
    cfg_div = 8'd1; cfg_period = 12'd19; cfg_width = 8'd9; cfg_bclk_inv = 1'b1;
    to_start(n);
    chk_int(n + 5, 30, "R7", "frame in progress kept old timing");
    to_start(n);
    chk_int(n, 40, "R7", "new timing after boundary");

    // drop enable mid-frame, then restart from zero (R6, R5)
    run(7);
    enable = 1'b0;
    run(4);
    enable = 1'b1;
    step();
    chk(frame_start, 1'b1, "R5", "restart opens a frame");
    run(50);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule